// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block produces the host read and write strobes of a parallel ATA channel for PIO and multiword DMA transfers. Every cycle is described by one packed 32-bit timing word. Separate fields in that word give the strobe-high time, the strobe-low time and the leading setup time. Cycles that access the command registers take their lengths from a different set of fields than data cycles do. All lengths are counted in bus clocks.

A request carries three things: a kind (data or command register), a direction and the timing word. The block accepts a request when it is idle, or in the final recovery clock of the cycle in flight. It then runs an optional setup phase, an active phase with the strobe low and a recovery phase with the strobe high. It reports the final recovery clock on a one-clock done pulse.

A request that is waiting during that final clock starts a back-to-back burst. It goes straight from recovery to its active phase and skips the setup phase.

Top module: `ata_strobe_gen`

## Requirements
- R1: For a data cycle, the strobe is low for timing_word[8:4]+1 consecutive clocks.
- R2: For a data cycle, the recovery phase (strobe high, busy high) that follows the active phase lasts timing_word[3:0]+1 clocks. The final clock of the recovery phase carries done.
- R3: For a command-register cycle (req_cmd=1), the strobe is low for timing_word[17:13]+1 clocks and the recovery phase lasts timing_word[12:9]+1 clocks. The data fields are ignored.
- R4: A cycle accepted from idle starts with a setup phase of N clocks, with busy high and both strobes high. N is timing_word[24:22] for data cycles and timing_word[27:25] for command-register cycles. N=0 means the cycle has no setup phase.
- R5: req_write=1 drives wr_n low in the active phase and req_write=0 drives rd_n low. The other strobe stays high, and rd_n and wr_n are never low together.
- R6: A request presented while done is high is accepted on that clock edge. Its active phase begins on the next clock, with no setup phase.
- R7: busy rises on the clock after acceptance and stays high through the done clock. done is high for exactly one clock per accepted request.
- R8: The kind, direction and timing word are captured at acceptance. Changing them afterwards does not alter the cycle in flight. A request held while busy is high and done is low is not accepted until done or idle.
- R9: Bits 31:28 and 21:18 of the timing word have no effect on any phase length.
- R10: After reset, rd_n and wr_n are high and busy and done are low. Both strobes stay high whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 1 | 1 = command-register cycle, 0 = data cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| timing_word | input | 32 | Packed timing fields for the request |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Final recovery clock of a cycle |

## Verification
The strobe outputs decode the phase register directly, so a wrong phase shows on rd_n, wr_n or busy in the same clock. A counter that reloads from the wrong field, or that drops a clock, changes the measured low or high run length of that very cycle. A setup phase entered wrongly on a burst shows up as strobe-high clocks ahead of the active run. A wrong latch of the direction bit shows as the wrong strobe going low. The scoreboard measures each setup, active and recovery run and compares it at the done pulse that closes the cycle. Any error is therefore reported at most one cycle length after it arises.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

    localparam int TW_W    = 32;
    localparam int SETUP_W = 3;
    localparam int ACT_W   = 5;
    localparam int REC_W   = 4;
    localparam int CNT_W   = (ACT_W > REC_W) ? ACT_W : REC_W;

    // field positions: index 0 = data cycle, 1 = command-register cycle
    localparam int D_REC_LSB = 0;
    localparam int D_ACT_LSB = 4;
    localparam int C_REC_LSB = 9;
    localparam int C_ACT_LSB = 13;
    localparam int D_SU_LSB  = 22;
    localparam int C_SU_LSB  = 25;

    function automatic logic [TW_W-1:0] field_mask(input int lsb, input int w);
        logic [TW_W-1:0] one;
        one = {{(TW_W-1){1'b0}}, 1'b1};
        return ((one << w) - one) << lsb;
    endfunction

    localparam logic [TW_W-1:0] TIME_MASK =
        field_mask(D_REC_LSB, REC_W) | field_mask(D_ACT_LSB, ACT_W) |
        field_mask(C_REC_LSB, REC_W) | field_mask(C_ACT_LSB, ACT_W) |
        field_mask(D_SU_LSB, SETUP_W) | field_mask(C_SU_LSB, SETUP_W);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [ACT_W-1:0]   act;
        logic [REC_W-1:0]   rec;
    } cyc_time_t;

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic               wr;
        logic [ACT_W-1:0]   act;
        logic [REC_W-1:0]   rec;
    } seq_state_t;

endpackage

// File: rtl/ata_tword_decode.sv
module ata_tword_decode
    import ata_strobe_pkg::*;
(
    input  logic [TW_W-1:0] tword,
    input  logic            is_cmd,
    output cyc_time_t       tsel
);

    logic [TW_W-1:0] masked;
    cyc_time_t       cand [2];

    // mode-enable and UDMA bits are cleared before any field is read
    assign masked = tword & TIME_MASK;

    for (genvar k = 0; k < 2; k++) begin : g_kind
        localparam int AL = (k == 0) ? D_ACT_LSB : C_ACT_LSB;
        localparam int RL = (k == 0) ? D_REC_LSB : C_REC_LSB;
        localparam int SL = (k == 0) ? D_SU_LSB  : C_SU_LSB;
        assign cand[k].act   = masked[AL +: ACT_W];
        assign cand[k].rec   = masked[RL +: REC_W];
        assign cand[k].setup = masked[SL +: SETUP_W];
    end

    assign tsel = is_cmd ? cand[1] : cand[0];

endmodule

// File: rtl/ata_phase_ctrl.sv
module ata_phase_ctrl
    import ata_strobe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  cyc_time_t  tsel,
    output phase_e     phase,
    output logic       wr_dir,
    output logic       last
);

    seq_state_t st_d, st_q;
    logic       accept;

    always_comb begin
        st_d   = st_q;
        accept = req_valid &&
                 ((st_q.ph == PH_IDLE) || (st_q.ph == PH_RECOV && st_q.cnt == '0));
        case (st_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    st_d.wr  = req_write;
                    st_d.act = tsel.act;
                    st_d.rec = tsel.rec;
                    if (tsel.setup != '0) begin
                        st_d.ph  = PH_SETUP;
                        st_d.cnt = CNT_W'(tsel.setup) - CNT_W'(1);
                    end else begin
                        st_d.ph  = PH_ACTIVE;
                        st_d.cnt = CNT_W'(tsel.act);
                    end
                end
            end
            PH_SETUP: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_ACTIVE;
                    st_d.cnt = CNT_W'(st_q.act);
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_RECOV;
                    st_d.cnt = CNT_W'(st_q.rec);
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                if (st_q.cnt == '0) begin
                    if (accept) begin
                        st_d.wr  = req_write;
                        st_d.act = tsel.act;
                        st_d.rec = tsel.rec;
                        st_d.ph  = PH_ACTIVE;
                        st_d.cnt = CNT_W'(tsel.act);
                    end else begin
                        st_d.ph  = PH_IDLE;
                        st_d.cnt = '0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, wr: 1'b0, act: '0, rec: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.ph;
    assign wr_dir = st_q.wr;
    assign last   = (st_q.cnt == '0);

    // R7: an accepted request always leaves idle
    p_accept_leaves_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q.ph != PH_IDLE));

    // R6: acceptance during the done clock enters the active phase directly
    p_burst_skips_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q.ph == PH_RECOV) |=> (st_q.ph == PH_ACTIVE));

    // R8: captured cycle parameters hold while a cycle runs
    p_capture_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && !accept) |=>
            ($stable(st_q.wr) && $stable(st_q.act) && $stable(st_q.rec)));

    // R1: the active countdown never exceeds the captured active field
    p_active_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_ACTIVE) |-> (st_q.cnt <= CNT_W'(st_q.act)));

endmodule

// File: rtl/ata_strobe_out.sv
module ata_strobe_out
    import ata_strobe_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase,
    input  logic   wr_dir,
    input  logic   last,
    output logic   rd_n,
    output logic   wr_n,
    output logic   busy,
    output logic   done
);

    logic strobe_on;

    assign strobe_on = (phase == PH_ACTIVE);
    assign rd_n      = !(strobe_on && !wr_dir);
    assign wr_n      = !(strobe_on &&  wr_dir);
    assign busy      = (phase != PH_IDLE);
    assign done      = (phase == PH_RECOV) && last;

    // R5: never both strobes low
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));

    // R7: done lasts a single clock
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: strobes idle high outside a cycle
    p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n));

    // R7: busy is high during done
    p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
    import ata_strobe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_cmd,
    input  logic            req_write,
    input  logic [TW_W-1:0] timing_word,
    output logic            rd_n,
    output logic            wr_n,
    output logic            busy,
    output logic            done
);

    cyc_time_t tsel;
    phase_e    phase;
    logic      wr_dir;
    logic      last;

    ata_tword_decode u_decode (
        .tword  (timing_word),
        .is_cmd (req_cmd),
        .tsel   (tsel)
    );

    ata_phase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tsel      (tsel),
        .phase     (phase),
        .wr_dir    (wr_dir),
        .last      (last)
    );

    ata_strobe_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .wr_dir (wr_dir),
        .last   (last),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .busy   (busy),
        .done   (done)
    );

endmodule

// File: tb/ata_strobe_gen_bench.sv
module ata_strobe_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct {
        int su;
        int act;
        int rec;
        bit wr;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_cmd = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] timing_word = '0;
    logic        rd_n, wr_n, busy, done;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];
    bit   mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_strobe_gen u_ata_strobe_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .req_write   (req_write),
        .timing_word (timing_word),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .busy        (busy),
        .done        (done)
    );

    task automatic chk(input bit ok, input string req, input int actual, input int expect_v,
                       input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expect_v);
        end
    endtask

    function automatic logic [31:0] mk_word(input int dsu, input int dact, input int drec,
                                            input int csu, input int cact, input int crec,
                                            input int mode, input int gap);
        logic [31:0] w;
        w = '0;
        w[3:0]   = 4'(drec);
        w[8:4]   = 5'(dact);
        w[12:9]  = 4'(crec);
        w[17:13] = 5'(cact);
        w[21:18] = 4'(gap);
        w[24:22] = 3'(dsu);
        w[27:25] = 3'(csu);
        w[31:28] = 4'(mode);
        return w;
    endfunction

    // driver: present a request, wait for acceptance, push the expectation
    task automatic issue(input bit cmd, input bit wr, input logic [31:0] w, input string tag);
        exp_t e;
        bit   burst;
        @(negedge clk);
        req_valid   = 1'b1;
        req_cmd     = cmd;
        req_write   = wr;
        timing_word = w;
        while (busy && !done) @(negedge clk);
        burst = busy;
        if (cmd) begin
            e.act = int'(w[17:13]) + 1;
            e.rec = int'(w[12:9]) + 1;
            e.su  = burst ? 0 : int'(w[27:25]);
        end else begin
            e.act = int'(w[8:4]) + 1;
            e.rec = int'(w[3:0]) + 1;
            e.su  = burst ? 0 : int'(w[24:22]);
        end
        e.wr  = wr;
        e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
        #1;
        // R8: scramble everything once captured
        req_valid   = 1'b0;
        req_cmd     = ~cmd;
        req_write   = ~wr;
        timing_word = ~w;
    endtask

    // monitor: measure phase runs, compare on done
    int  su_c = 0, act_c = 0, rec_c = 0;
    bit  seen_act = 1'b0, dir_wr = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            chk(rd_n || wr_n, "R5", 0, 1, "both strobes low");
            chk(busy || (rd_n && wr_n), "R10", 0, 1, "strobe low while not busy");
            if (busy) begin
                if (!rd_n || !wr_n) begin
                    act_c++;
                    seen_act = 1'b1;
                    dir_wr   = !wr_n;
                end else if (!seen_act) begin
                    su_c++;
                end else begin
                    rec_c++;
                end
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", 1, 0, "done with no request outstanding");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(su_c == e.su, "R4", su_c, e.su, {e.tag, " setup clocks"});
                    chk(act_c == e.act, "R1/R3", act_c, e.act, {e.tag, " active clocks"});
                    chk(rec_c == e.rec, "R2/R3", rec_c, e.rec, {e.tag, " recovery clocks"});
                    chk(dir_wr == e.wr, "R5", int'(dir_wr), int'(e.wr), {e.tag, " direction"});
                end
                su_c = 0; act_c = 0; rec_c = 0; seen_act = 1'b0;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(rd_n == 1'b1, "R10", int'(rd_n), 1, "rd_n in reset");
        chk(wr_n == 1'b1, "R10", int'(wr_n), 1, "wr_n in reset");
        chk(busy == 1'b0, "R10", int'(busy), 0, "busy in reset");
        chk(done == 1'b0, "R10", int'(done), 0, "done in reset");
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R4: data read with setup
        issue(1'b0, 1'b0, mk_word(3, 5, 2, 6, 9, 7, 0, 0), "R1 data read");
        repeat (40) @(negedge clk);
        // R4: data write without setup
        issue(1'b0, 1'b1, mk_word(0, 2, 6, 5, 1, 3, 0, 0), "R4 data write no setup");
        repeat (40) @(negedge clk);
        // R3: command read, fields differ from data fields
        issue(1'b1, 1'b0, mk_word(1, 7, 1, 4, 3, 9, 0, 0), "R3 cmd read");
        repeat (40) @(negedge clk);
        // R3 R4: command write, largest fields
        issue(1'b1, 1'b1, mk_word(0, 0, 0, 7, 31, 15, 0, 0), "R3 cmd write max");
        repeat (80) @(negedge clk);
        // R1 R2: smallest fields
        issue(1'b0, 1'b1, mk_word(0, 0, 0, 0, 0, 0, 0, 0), "R2 data min");
        repeat (20) @(negedge clk);
        // R9: mode and gap bits set, lengths unchanged
        issue(1'b0, 1'b0, mk_word(2, 4, 3, 1, 1, 1, 15, 15), "R9 mode bits");
        repeat (40) @(negedge clk);
        issue(1'b1, 1'b1, mk_word(1, 1, 1, 2, 6, 2, 10, 5), "R9 cmd mode bits");
        repeat (40) @(negedge clk);
        // R6: back-to-back burst, mixed kinds and directions
        issue(1'b0, 1'b1, mk_word(5, 3, 1, 2, 2, 2, 0, 0), "R6 burst first");
        issue(1'b0, 1'b0, mk_word(7, 1, 4, 6, 6, 6, 0, 0), "R6 burst second");
        issue(1'b1, 1'b1, mk_word(3, 3, 3, 7, 4, 0, 0, 0), "R6 burst third");
        issue(1'b0, 1'b1, mk_word(4, 0, 0, 4, 4, 4, 0, 0), "R6 burst fourth");
        repeat (60) @(negedge clk);
        // R8: fresh cycle after burst uses setup again
        issue(1'b1, 1'b0, mk_word(0, 0, 0, 3, 2, 1, 0, 0), "R8 post-burst setup");
        repeat (40) @(negedge clk);

        chk(exp_q.size() == 0, "R7", exp_q.size(), 0, "outstanding requests at end");
        chk(busy == 1'b0, "R7", int'(busy), 0, "busy after all cycles");
        chk(rd_n && wr_n, "R10", int'(rd_n && wr_n), 1, "strobes high at end");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule